// File: doc/BRIEF.md
# Output Clock Divider with Gradual Power-Down Ramp

This block derives an output clock from a fast oscillator clock by dividing it by 1, 2, 4 or 8. A 2-bit code picks the ratio, and the output keeps a 50% duty cycle at every ratio. When the code is 0, the output is the oscillator clock itself. All other ratios come from a toggling register.

A power-down request does not change the frequency in one jump. A slow sequencer runs on a separate reference clock. It moves an extra power-of-two division one step at a time: 1, 2, 4, 8, 16. Each step is held for a fixed number of reference cycles. When the request is released, the sequencer walks back the same way, so the programmed rate returns in four discrete steps. If the request flips while a ramp is in progress, the walk turns around at the current step.

The step count crosses into the oscillator domain in Gray code through a two-flop synchronizer. The divider takes up a new ratio only at the start of an output high phase, so the output never produces a runt pulse.

Top module: `odiv_pd_ramp`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low. Reset clears the ramp to no extra division.
- R2: With the ramp idle, `div_sel` = n (0 to 3) gives an output period of 2^n `vco_clk` cycles. With n = 0, `clk_out` follows `vco_clk`.
- R3: Every output period is high for exactly half of its length, in every ratio and during ramps.
- R4: While `pwr_dn` is held high, the extra division doubles once per step until it reaches 16 and then holds there. The output period becomes 16 times the programmed period.
- R5: `pwr_dn` passes through a 2-stage synchronizer on `ref_clk`. Each ramp step then lasts DWELL_CYC `ref_clk` cycles (default 16), and the step value changes by at most one per `ref_clk` cycle.
- R6: After `pwr_dn` falls from the fully ramped state, the output period changes exactly four times, halving each time, and ends at the programmed period.
- R7: When `pwr_dn` changes direction mid-ramp, the ramp continues from the step it has reached. It never moves beyond that step in the old direction.
- R8: A new total ratio 2^(div_sel + step) takes effect only at the `vco_clk` edge that starts an output high phase. The step value used is the one seen through the 2-stage synchronizer in the `vco_clk` domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast clock that is divided |
| ref_clk | input | 1 | Slow clock that paces the ramp |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| div_sel | input | SEL_W | Programmed ratio code: ratio = 2^div_sel |
| pwr_dn | input | 1 | Power-down request; high ramps the output to 1/16 rate |
| clk_out | output | 1 | Divided output clock |

## Verification
On every cycle, the assertions check the following:
- The ramp step moves by at most one, stays within range, and moves only in the direction of the synchronized request.
- The applied ratio changes only at the start of a high phase.

Other behaviours can only be shown by the bench's scenarios, which compare a period-position reference model against `clk_out` every half cycle:
- the measured periods for each code,
- the 50% duty across ramps,
- the dwell before the first step,
- the four-step return,
- the turn-around.

// File: rtl/odiv_pkg.sv
package odiv_pkg;

   typedef enum logic [1:0] {
      RAMP_IDLE = 2'd0,
      RAMP_SLOW = 2'd1,
      RAMP_FAST = 2'd2
   } ramp_dir_e;

   function automatic logic [7:0] to_gray(logic [7:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [7:0] from_gray(logic [7:0] g);
      logic [7:0] b;
      b[7] = g[7];
      for (int i = 6; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/odiv_sync.sv
module odiv_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/odiv_ramp_seq.sv
module odiv_ramp_seq
   import odiv_pkg::*;
#(
   parameter int RAMP_STEPS  = 4,
   parameter int DWELL_CYC   = 16,
   parameter int SYNC_STAGES = 2,
   localparam int STEP_W = $clog2(RAMP_STEPS + 1),
   localparam int DW_W   = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              pwr_dn,
   output logic              pd_sync_o,
   output logic [STEP_W-1:0] step_o,
   output logic [STEP_W-1:0] step_gray_o
);

   logic              pd_s;
   ramp_dir_e         dir;
   logic [STEP_W-1:0] step_q, step_nx;
   logic [DW_W-1:0]   dwell_q, dwell_nx;

   odiv_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pd_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (pwr_dn),
      .q     (pd_s)
   );

   always_comb begin
      dir = RAMP_IDLE;
      if (pd_s && step_q != STEP_W'(RAMP_STEPS)) dir = RAMP_SLOW;
      else if (!pd_s && step_q != '0)            dir = RAMP_FAST;
      step_nx  = step_q;
      dwell_nx = dwell_q;
      if (dir == RAMP_IDLE) begin
         dwell_nx = '0;
      end else if (dwell_q == DW_W'(DWELL_CYC - 1)) begin
         dwell_nx = '0;
         step_nx  = (dir == RAMP_SLOW) ? step_q + 1'b1 : step_q - 1'b1;
      end else begin
         dwell_nx = dwell_q + 1'b1;
      end
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q      <= '0;
         dwell_q     <= '0;
         step_gray_o <= '0;
      end else begin
         step_q      <= step_nx;
         dwell_q     <= dwell_nx;
         step_gray_o <= STEP_W'(to_gray(8'(step_nx)));
      end
   end

   assign step_o    = step_q;
   assign pd_sync_o = pd_s;

endmodule

// File: rtl/odiv_divider.sv
module odiv_divider #(
   parameter int SEL_W  = 2,
   parameter int STEP_W = 3,
   parameter int KMAX   = 7,
   localparam int KW    = $clog2(KMAX + 1),
   localparam int CNT_W = (KMAX > 1) ? KMAX - 1 : 1
) (
   input  logic              vco_clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  div_sel,
   input  logic [STEP_W-1:0] step,
   output logic              byp_o,
   output logic              tgl_o,
   output logic [KW-1:0]     k_o
);

   logic [KW-1:0]    k_q, k_new;
   logic [CNT_W-1:0] cnt_q;
   logic             byp_q, tgl_q, boundary;

   function automatic logic [CNT_W-1:0] half_m1(logic [KW-1:0] k);
      logic [CNT_W:0] one_sh;
      if (k == '0) return '0;
      one_sh = (CNT_W+1)'(1) << (k - 1'b1);
      return CNT_W'(one_sh - 1'b1);
   endfunction

   assign k_new    = KW'(div_sel) + KW'(step);
   assign boundary = byp_q || (!tgl_q && cnt_q == '0);

   always_ff @(posedge vco_clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_q <= 1'b0;
         tgl_q <= 1'b0;
         cnt_q <= '0;
         k_q   <= '0;
      end else if (boundary) begin
         k_q <= k_new;
         if (k_new == '0) begin
            byp_q <= 1'b1;
            tgl_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            byp_q <= 1'b0;
            tgl_q <= 1'b1;
            cnt_q <= half_m1(k_new);
         end
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end else begin
         tgl_q <= 1'b0;
         cnt_q <= half_m1(k_q);
      end
   end

   assign byp_o = byp_q;
   assign tgl_o = tgl_q;
   assign k_o   = k_q;

endmodule

// File: rtl/odiv_pd_ramp.sv
module odiv_pd_ramp
   import odiv_pkg::*;
#(
   parameter int SEL_W       = 2,
   parameter int RAMP_STEPS  = 4,
   parameter int DWELL_CYC   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             vco_clk,
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             pwr_dn,
   output logic             clk_out
);

   localparam int STEP_W = $clog2(RAMP_STEPS + 1);
   localparam int KMAX   = (2 ** SEL_W - 1) + RAMP_STEPS;
   localparam int KW     = $clog2(KMAX + 1);

   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("SEL_W out of range");
   end
   if (RAMP_STEPS < 1 || STEP_W > 8 || KMAX > 16) begin : g_bad_ramp
      $error("RAMP_STEPS out of range");
   end
   if (DWELL_CYC < 1) begin : g_bad_dwell
      $error("DWELL_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              pd_s_ref;
   logic [STEP_W-1:0] step_ref, gray_ref, gray_vco, step_vco;
   logic              byp_v, tgl_v;
   logic [KW-1:0]     k_v;

   odiv_ramp_seq #(
      .RAMP_STEPS  (RAMP_STEPS),
      .DWELL_CYC   (DWELL_CYC),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_seq (
      .ref_clk     (ref_clk),
      .rst_n       (rst_n),
      .pwr_dn      (pwr_dn),
      .pd_sync_o   (pd_s_ref),
      .step_o      (step_ref),
      .step_gray_o (gray_ref)
   );

   odiv_sync #(.WIDTH(STEP_W), .STAGES(SYNC_STAGES)) u_step_sync (
      .clk   (vco_clk),
      .rst_n (rst_n),
      .d     (gray_ref),
      .q     (gray_vco)
   );

   assign step_vco = STEP_W'(from_gray(8'(gray_vco)));

   odiv_divider #(
      .SEL_W  (SEL_W),
      .STEP_W (STEP_W),
      .KMAX   (KMAX)
   ) u_div (
      .vco_clk (vco_clk),
      .rst_n   (rst_n),
      .div_sel (div_sel),
      .step    (step_vco),
      .byp_o   (byp_v),
      .tgl_o   (tgl_v),
      .k_o     (k_v)
   );

   assign clk_out = byp_v ? vco_clk : tgl_v;

endmodule

// File: rtl/odiv_pd_ramp_chk.sv
module odiv_pd_ramp_chk #(
   parameter int RAMP_STEPS = 4,
   parameter int STEP_W     = 3,
   parameter int KW         = 3
) (
   input logic              ref_clk,
   input logic              vco_clk,
   input logic              rst_n,
   input logic              pd_s,
   input logic [STEP_W-1:0] step,
   input logic              byp,
   input logic              tgl,
   input logic [KW-1:0]     k
);

   // R5: step moves by at most one per reference cycle
   a_r5_step_by_one: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (int'(step) - int'($past(step))) inside {-1, 0, 1});

   // R4: step never exceeds the full ramp depth
   a_r4_step_range: assert property (@(posedge ref_clk) disable iff (!rst_n)
      int'(step) <= RAMP_STEPS);

   // R4 / R7: while the request is high the step only grows
   a_r7_slow_dir: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $past(pd_s) |-> step >= $past(step));

   // R6 / R7: while the request is low the step only shrinks
   a_r6_fast_dir: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !$past(pd_s) |-> step <= $past(step));

   // R8: applied ratio changes only where a high phase begins
   a_r8_ratio_at_boundary: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (k != $past(k)) |-> (tgl || byp));

endmodule

bind odiv_pd_ramp odiv_pd_ramp_chk #(
   .RAMP_STEPS (RAMP_STEPS),
   .STEP_W     (STEP_W),
   .KW         (KW)
) u_chk (
   .ref_clk (ref_clk),
   .vco_clk (vco_clk),
   .rst_n   (rst_n),
   .pd_s    (pd_s_ref),
   .step    (step_ref),
   .byp     (byp_v),
   .tgl     (tgl_v),
   .k       (k_v)
);

// File: tb/odiv_pd_ramp_bench.sv
`timescale 1ns/1ps
module odiv_pd_ramp_bench;

   localparam int RSTEPS = 4;
   localparam int DWELL  = 16;

   logic       vco_clk = 1'b0;
   logic       ref_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic [1:0] div_sel = 2'd0;
   logic       pwr_dn  = 1'b0;
   logic       clk_out;

   int  errors = 0;
   int  checks = 0;
   bit  done   = 1'b0;

   odiv_pd_ramp u_odiv_pd_ramp (
      .vco_clk (vco_clk),
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .div_sel (div_sel),
      .pwr_dn  (pwr_dn),
      .clk_out (clk_out)
   );

   always #4 vco_clk = ~vco_clk;
   initial begin
      #3;
      forever begin
         ref_clk = 1'b1; #16;
         ref_clk = 1'b0; #16;
      end
   end

   // reference model: ramp in the reference domain
   int m_pd1, m_pd2, m_step, m_dwell;
   always @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pd1 = 0; m_pd2 = 0; m_step = 0; m_dwell = 0;
      end else begin
         if ((m_pd2 != 0 && m_step < RSTEPS) || (m_pd2 == 0 && m_step > 0)) begin
            m_dwell++;
            if (m_dwell == DWELL) begin
               m_dwell = 0;
               m_step  = (m_pd2 != 0) ? m_step + 1 : m_step - 1;
            end
         end else begin
            m_dwell = 0;
         end
         m_pd2 = m_pd1;
         m_pd1 = int'(pwr_dn);
      end
   end

   // reference model: position within the current output period
   int m_s1, m_s2, m_len, m_pos;
   always @(posedge vco_clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_len = 0; m_pos = 0;
      end else begin
         if (m_pos + 1 >= m_len) begin
            m_len = 1 << (int'(div_sel) + m_s2);
            m_pos = 0;
         end else begin
            m_pos++;
         end
         m_s2 = m_s1;
         m_s1 = m_step;
      end
   end

   // period measurement in half-cycle units
   int  hidx = 0, last_rise = -1, hi_cnt = 0, last_hi = 0;
   int  last_per = 0, max_per = 0, per_changes = 0, duty_bad = 0;
   bit  prev_o = 1'b0;

   task automatic chk(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic take_sample(bit hiph);
      bit e;
      if (m_len == 0)      e = 1'b0;
      else if (m_len == 1) e = hiph;
      else                 e = (m_pos < m_len / 2);
      checks++;
      if (clk_out !== e) begin
         errors++;
         $display("FAIL R8 cycle model at %0t actual=%0b expected=%0b", $time, clk_out, e);
      end
      hidx++;
      if (clk_out && !prev_o) begin
         if (last_rise >= 0) begin
            int per;
            per = hidx - last_rise;
            if (last_hi * 2 != per) duty_bad++;
            if (last_per != 0 && per != last_per) per_changes++;
            last_per = per;
            if (per > max_per) max_per = per;
         end
         last_rise = hidx;
         hi_cnt = 0;
      end
      if (clk_out) hi_cnt++;
      if (!clk_out && prev_o) last_hi = hi_cnt;
      prev_o = clk_out;
   endtask

   initial begin
      forever begin
         @(posedge vco_clk); #1; take_sample(1'b1);
         @(negedge vco_clk); #1; take_sample(1'b0);
      end
   end

   task automatic wait_vco(int n);
      repeat (n) @(negedge vco_clk);
      #2;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: low output during reset
      for (int i = 0; i < 3; i++) begin
         wait_vco(1);
         chk("R1", int'(clk_out), 0, "output during reset");
      end
      rst_n = 1'b1;
      wait_vco(20);

      // R2 / R3: each programmed ratio with the ramp idle
      for (int s = 0; s < 4; s++) begin
         div_sel = 2'(s);
         wait_vco(300);
         chk("R2", last_per, 2 * (1 << s), "period in half cycles");
         chk("R3", last_hi * 2, last_per, "high half cycles doubled");
      end

      // R5: no change before the first dwell ends
      div_sel = 2'd1;
      wait_vco(100);
      per_changes = 0;
      pwr_dn = 1'b1;
      wait_vco(32);
      chk("R5", last_per, 4, "period before first dwell ends");
      chk("R5", per_changes, 0, "changes before first dwell ends");

      // R4: reaches one sixteenth of programmed rate and holds
      wait_vco(400);
      chk("R4", last_per, 64, "fully ramped period");
      chk("R4", per_changes, 4, "steps on the way down");
      wait_vco(200);
      chk("R4", last_per, 64, "ramped period held");

      // R6: four steps back to the programmed rate
      per_changes = 0;
      duty_bad = 0;
      pwr_dn = 1'b0;
      wait_vco(450);
      chk("R6", per_changes, 4, "steps on the way up");
      chk("R6", last_per, 4, "final period");
      chk("R3", duty_bad, 0, "periods with unequal halves");

      // R7: reversal part way down
      max_per = 0;
      duty_bad = 0;
      pwr_dn = 1'b1;
      wait_vco(168);
      pwr_dn = 1'b0;
      wait_vco(400);
      chk("R7", max_per, 16, "deepest period after reversal");
      chk("R7", last_per, 4, "period after reversal settles");
      chk("R3", duty_bad, 0, "unequal halves during reversal");

      // R8: full ramp from the largest code
      div_sel = 2'd3;
      wait_vco(100);
      pwr_dn = 1'b1;
      wait_vco(700);
      chk("R8", last_per, 256, "deepest period at largest code");
      pwr_dn = 1'b0;
      wait_vco(700);
      chk("R8", last_per, 16, "largest code restored");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule